// File: doc/BRIEF.md
# Two-Space Bus Slave Controller

This block is the only slave on the bus of a single processor. Every bus request is one 32-bit word. Bits [23:0] carry the byte address, and bits [31:24] carry a control byte. The control byte picks one of two address spaces. In the memory space the block reads and writes an on-chip synchronous word store, one byte lane per byte. In the register space it serves a few inter-processor registers: a device identity, a message-pending status and a console output port.

The control byte is laid out as bit 31 lock flag, bit 30 space select (1 = register space), bits 29:28 length code (0/1/2/3 = 1/2/4/8 bytes), bits 27:25 modifier, bit 24 direction (1 = write). Data travels right-aligned in a 64-bit word. The low three address bits give the byte offset inside a memory word, and a transfer that would run past the end of the word is cut off at that boundary. A response comes back on the cycle after every request, with no wait states. Console bytes go into a small FIFO that feeds a valid/ready byte transmitter. A pending-message flag can be raised by a pulse at any time, independent of bus traffic.

Top module: `bus_slave_ctrl`

## Requirements
- R1: While reset is asserted and right after it, rsp_valid, tx_valid and drop_count are 0, and the pending flag reads 0.
- R2: Every cycle with req_valid high produces rsp_valid high on exactly the next cycle, and only then. A write response carries rsp_rdata = 0.
- R3: A memory write (bit 30 = 0, bit 24 = 1) stores byte i of req_wdata into byte lane offset+i of word address[MEM_AW+2:3], for i below the length. Lanes past byte 7 and all lanes outside the transfer keep their contents.
- R4: A memory read returns the selected bytes right-aligned in rsp_rdata, with every byte at or above the length, or past the end of the word, set to zero.
- R5: Address bits above bit MEM_AW+2 are ignored in the memory space, so addresses that differ only there alias the same word.
- R6: A register-space read of address 0x000000 returns dev_id, zero-extended, as sampled in the request cycle.
- R7: A register-space read of address 0x000002 returns the pending flag in bit 0 and clears it. An ipc_raise pulse sets the flag, and a raise in the same cycle as that read leaves the flag set.
- R8: A register-space write to address 0x000002 queues req_wdata[7:0] for the transmitter. Bytes leave in order on tx_data while tx_valid is high, one per cycle in which tx_ready is also high, and tx_data holds while the transmitter stalls.
- R9: A console write that finds FIFO_DEPTH bytes already queued is dropped and adds 1 to drop_count, which stops at its all-ones value.
- R10: Register-space reads of any other address return 0. Register-space writes to any other address change neither memory nor the console queue.
- R11: The lock flag and the modifier bits have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_word | input | 32 | Control byte and address |
| req_wdata | input | 64 | Right-aligned write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Right-aligned read data |
| dev_id | input | ID_W | Device identity value |
| ipc_raise | input | 1 | Pulse that marks a message pending |
| tx_valid | output | 1 | Console byte available |
| tx_data | output | 8 | Console byte |
| tx_ready | input | 1 | Transmitter takes the byte |
| drop_count | output | DROP_W | Saturating count of dropped console bytes |

## Verification
A request launched in one cycle has its response, its memory or flag update and its console push all due at the next rising edge. The first sample where they can be seen is the falling edge after that edge. The console outputs and drop_count move at the same edge as the handshake or push that causes them. The bench updates a behavioural model at every rising edge, drives inputs and samples outputs only at falling edges, and compares the model with the outputs at every falling edge. Each result is therefore checked in the cycle it is due and in no other cycle.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 64;
  localparam int BYTES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(BYTES);

  typedef enum logic [1:0] {LEN_1 = 2'd0, LEN_2 = 2'd1, LEN_4 = 2'd2, LEN_8 = 2'd3} len_e;

  typedef struct packed {
    logic       lock;
    logic       space;
    len_e       len;
    logic [2:0] modf;
    logic       wr;
  } ctrl_t;

  typedef struct packed {
    ctrl_t              ctrl;
    logic [ADDR_W-1:0]  addr;
  } req_t;

  typedef enum logic [1:0] {RSP_ZERO = 2'd0, RSP_MEM = 2'd1, RSP_REG = 2'd2} rsp_src_e;

  localparam logic [ADDR_W-1:0] REG_ID_ADDR   = 24'h000000;
  localparam logic [ADDR_W-1:0] REG_STAT_ADDR = 24'h000002;
endpackage

// File: rtl/bsc_decode.sv
module bsc_decode
  import bsc_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              req_valid,
  input  logic [31:0]       req_word,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              id_rd,
  output logic              stat_rd,
  output logic              con_wr,
  output logic [MEM_AW-1:0] word_idx,
  output logic [OFF_W-1:0]  byte_off,
  output logic [BYTES-1:0]  len_mask
);
  req_t r;
  logic unused_bits;

  assign r = req_t'(req_word);
  // lock flag and modifier bits are deliberately not decoded
  assign unused_bits = ^{r.ctrl.lock, r.ctrl.modf};

  always_comb begin
    mem_rd   = req_valid & ~r.ctrl.space & ~r.ctrl.wr;
    mem_wr   = req_valid & ~r.ctrl.space &  r.ctrl.wr;
    id_rd    = req_valid &  r.ctrl.space & ~r.ctrl.wr & (r.addr == REG_ID_ADDR);
    stat_rd  = req_valid &  r.ctrl.space & ~r.ctrl.wr & (r.addr == REG_STAT_ADDR);
    con_wr   = req_valid &  r.ctrl.space &  r.ctrl.wr & (r.addr == REG_STAT_ADDR);
    word_idx = r.addr[OFF_W +: MEM_AW];
    byte_off = r.addr[OFF_W-1:0];
    case (r.ctrl.len)
      LEN_1:   len_mask = BYTES'(8'h01);
      LEN_2:   len_mask = BYTES'(8'h03);
      LEN_4:   len_mask = BYTES'(8'h0F);
      default: len_mask = BYTES'(8'hFF);
    endcase
  end
endmodule

// File: rtl/bsc_mem.sv
module bsc_mem
  import bsc_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [MEM_AW-1:0] idx,
  input  logic [BYTES-1:0]  lane_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 2 ** MEM_AW;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [7:0] lane_arr [DEPTH];
    logic [7:0] lane_q;

    always_ff @(posedge clk) begin
      if (wr_en && lane_en[g]) begin
        lane_arr[idx] <= wdata[8*g +: 8];
      end
      if (rd_en) begin
        lane_q <= lane_arr[idx];
      end
    end

    assign rdata[8*g +: 8] = lane_q;
  end
endmodule

// File: rtl/bsc_fifo.sv
module bsc_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         full,
  output logic         empty,
  output logic [W-1:0] head
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign head  = slots[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) begin
      wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop) begin
      rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      slots[wr_ptr_q] <= push_data;
    end
  end
endmodule

// File: rtl/bsc_ipc.sv
module bsc_ipc
  import bsc_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DROP_W     = 8,
  parameter int ID_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_rd,
  input  logic              stat_rd,
  input  logic              con_wr,
  input  logic [7:0]        con_byte,
  input  logic              ipc_raise,
  input  logic [ID_W-1:0]   dev_id,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic [DROP_W-1:0] drop_count
);
  logic              pend_q, pend_d;
  logic [DROP_W-1:0] drop_q, drop_d;
  logic              fifo_full, fifo_empty, push, pop;

  // pending flag: a raise always wins over a clearing status read
  always_comb begin
    pend_d = ipc_raise | (pend_q & ~stat_rd);
  end

  always_comb begin
    reg_rdata = '0;
    if (id_rd) begin
      reg_rdata[ID_W-1:0] = dev_id;
    end
    if (stat_rd) begin
      reg_rdata[0] = pend_q;
    end
  end

  assign push = con_wr & ~fifo_full;
  assign pop  = ~fifo_empty & tx_ready;

  bsc_fifo #(
    .DEPTH (FIFO_DEPTH),
    .W     (8)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (con_byte),
    .pop       (pop),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .head      (tx_data)
  );

  assign tx_valid = ~fifo_empty;

  always_comb begin
    drop_d = drop_q;
    if (con_wr && fifo_full && !(&drop_q)) begin
      drop_d = drop_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      drop_q <= '0;
    end else begin
      pend_q <= pend_d;
      drop_q <= drop_d;
    end
  end

  assign drop_count = drop_q;
endmodule

// File: rtl/bus_slave_ctrl.sv
module bus_slave_ctrl
  import bsc_pkg::*;
#(
  parameter int MEM_AW     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int DROP_W     = 8,
  parameter int ID_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_word,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  input  logic [ID_W-1:0]   dev_id,
  input  logic              ipc_raise,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic [DROP_W-1:0] drop_count
);
  logic              mem_rd, mem_wr, id_rd, stat_rd, con_wr;
  logic [MEM_AW-1:0] word_idx;
  logic [OFF_W-1:0]  byte_off;
  logic [BYTES-1:0]  len_mask, lane_en;
  logic [DATA_W-1:0] wdata_sh, mem_rdata, reg_rdata;

  bsc_decode #(
    .MEM_AW (MEM_AW)
  ) u_dec (
    .req_valid (req_valid),
    .req_word  (req_word),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .id_rd     (id_rd),
    .stat_rd   (stat_rd),
    .con_wr    (con_wr),
    .word_idx  (word_idx),
    .byte_off  (byte_off),
    .len_mask  (len_mask)
  );

  // align the transfer to its lanes; lanes past the word end fall off
  assign lane_en  = len_mask << byte_off;
  assign wdata_sh = req_wdata << {byte_off, 3'b000};

  bsc_mem #(
    .MEM_AW (MEM_AW)
  ) u_mem (
    .clk     (clk),
    .wr_en   (mem_wr),
    .rd_en   (mem_rd),
    .idx     (word_idx),
    .lane_en (lane_en),
    .wdata   (wdata_sh),
    .rdata   (mem_rdata)
  );

  bsc_ipc #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .DROP_W     (DROP_W),
    .ID_W       (ID_W)
  ) u_ipc (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_rd      (id_rd),
    .stat_rd    (stat_rd),
    .con_wr     (con_wr),
    .con_byte   (req_wdata[7:0]),
    .ipc_raise  (ipc_raise),
    .dev_id     (dev_id),
    .reg_rdata  (reg_rdata),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .drop_count (drop_count)
  );

  // response stage
  logic              rsp_valid_q, rsp_valid_d;
  rsp_src_e          src_q, src_d;
  logic [OFF_W-1:0]  off_q;
  logic [BYTES-1:0]  mask_q;
  logic [DATA_W-1:0] reg_q;
  logic [DATA_W-1:0] mem_aligned, lane_bits;

  always_comb begin
    rsp_valid_d = req_valid;
    if (mem_rd) begin
      src_d = RSP_MEM;
    end else if (id_rd || stat_rd) begin
      src_d = RSP_REG;
    end else begin
      src_d = RSP_ZERO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      src_q       <= RSP_ZERO;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (req_valid) begin
        src_q <= src_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      off_q  <= byte_off;
      mask_q <= len_mask;
      reg_q  <= reg_rdata;
    end
  end

  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      lane_bits[8*b +: 8] = {8{mask_q[b]}};
    end
    mem_aligned = mem_rdata >> {off_q, 3'b000};
    case (src_q)
      RSP_MEM: rsp_rdata = mem_aligned & lane_bits;
      RSP_REG: rsp_rdata = reg_q;
      default: rsp_rdata = '0;
    endcase
  end

  assign rsp_valid = rsp_valid_q;
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
  parameter int DROP_W = 8,
  parameter int ID_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [31:0]       req_word,
  input logic [ID_W-1:0]   dev_id,
  input logic              rsp_valid,
  input logic [63:0]       rsp_rdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic [DROP_W-1:0] drop_count
);
  logic unused_chk;
  assign unused_chk = ^{req_word[31], req_word[27:25]};

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2

  AST_WR_RSP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_word[24]) |=> (rsp_rdata == 64'd0)); // R2

  AST_BYTE_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_word[24] && !req_word[30] && req_word[29:28] == 2'b00)
      |=> (rsp_rdata[63:8] == 56'd0)); // R4

  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_word[24] && req_word[30] && req_word[23:0] == 24'd0)
      |=> (rsp_rdata == 64'($past(dev_id)))); // R6

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R8

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count))
      |-> (drop_count == DROP_W'($past(drop_count) + 1'b1))); // R9
endmodule

bind bus_slave_ctrl bsc_checker #(.DROP_W(DROP_W), .ID_W(ID_W)) chk_i (.*);

// File: tb/bus_slave_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_slave_ctrl_tb_top;
  localparam int MEM_AW = 8;
  localparam int DEPTH  = 2 ** MEM_AW;
  localparam int FDEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_word;
  logic [63:0] req_wdata;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic [15:0] dev_id;
  logic        ipc_raise;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready;
  logic [7:0]  drop_count;

  always #2 clk = ~clk;

  bus_slave_ctrl dut_i (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_word (req_word),
    .req_wdata (req_wdata), .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .dev_id (dev_id), .ipc_raise (ipc_raise), .tx_valid (tx_valid),
    .tx_data (tx_data), .tx_ready (tx_ready), .drop_count (drop_count)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0]  mem_m [int];
  logic [7:0]  q_m [$];
  bit          pend_m;
  int          drop_m;
  bit          exp_rsp_valid;
  logic [63:0] exp_rdata;
  bit          exp_txv;
  logic [7:0]  exp_txd;
  string       cur_tag = "R1";
  string       exp_tag = "R1";

  always @(posedge clk) begin
    bit          wr, sp, was_full;
    int          n, off, widx, key;
    logic [23:0] a;
    if (!rst_n) begin
      exp_rsp_valid = 1'b0;
      pend_m        = 1'b0;
      q_m.delete();
      drop_m        = 0;
    end else begin
      exp_rsp_valid = req_valid;
      exp_rdata     = '0;
      exp_tag       = cur_tag;
      was_full      = (q_m.size() == FDEPTH);
      wr = req_word[24];
      sp = req_word[30];
      a  = req_word[23:0];
      n  = 1 << req_word[29:28];
      off  = int'(a % 8);
      widx = int'((a / 8) % DEPTH);
      if (q_m.size() > 0 && tx_ready) void'(q_m.pop_front());
      if (req_valid && !sp) begin
        for (int i = 0; i < n; i++) begin
          if (off + i < 8) begin
            key = widx * 8 + off + i;
            if (wr) mem_m[key] = req_wdata[8*i +: 8];
            else exp_rdata[8*i +: 8] = mem_m.exists(key) ? mem_m[key] : 8'hxx;
          end
        end
      end
      if (req_valid && sp && !wr && a == 24'd0) exp_rdata = 64'(dev_id);
      if (req_valid && sp && !wr && a == 24'd2) exp_rdata = 64'(pend_m);
      pend_m = ipc_raise | (pend_m & !(req_valid && sp && !wr && a == 24'd2));
      if (req_valid && sp && wr && a == 24'd2) begin
        if (!was_full) q_m.push_back(req_wdata[7:0]);
        else if (drop_m < 255) drop_m++;
      end
    end
    exp_txv = (q_m.size() > 0);
    exp_txd = exp_txv ? q_m[0] : 8'h00;
  end

  // ---------------- comparison at falling edges ----------------
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1", "tx_valid", 64'(tx_valid), 64'd0);
        chk("R1", "drop_count", 64'(drop_count), 64'd0);
      end else begin
        chk("R2", "rsp_valid", 64'(rsp_valid), 64'(exp_rsp_valid));
        if (exp_rsp_valid) chk(exp_tag, "rsp_rdata", rsp_rdata, exp_rdata);
        chk("R8", "tx_valid", 64'(tx_valid), 64'(exp_txv));
        if (exp_txv) chk("R8", "tx_data", 64'(tx_data), 64'(exp_txd));
        chk("R9", "drop_count", 64'(drop_count), 64'(drop_m));
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=%0d expected=<60000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] mk(bit lock, bit sp, logic [1:0] len,
                                     logic [2:0] md, bit wr, logic [23:0] a);
    return {lock, sp, len, md, wr, a};
  endfunction

  task automatic rq(string tag, logic [31:0] w, logic [63:0] d);
    @(negedge clk);
    cur_tag = tag; req_valid = 1'b1; req_word = w; req_wdata = d; ipc_raise = 1'b0;
  endtask

  task automatic rq_raise(string tag, logic [31:0] w);
    @(negedge clk);
    cur_tag = tag; req_valid = 1'b1; req_word = w; req_wdata = '0; ipc_raise = 1'b1;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      req_valid = 1'b0; ipc_raise = 1'b0;
    end
  endtask

  task automatic raise_only();
    @(negedge clk);
    req_valid = 1'b0; ipc_raise = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_word = '0; req_wdata = '0;
    dev_id = 16'h5A3C; ipc_raise = 1'b0; tx_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: flag reads clear after reset
    rq("R1", mk(0, 1, 2'd1, 3'd0, 0, 24'h2), '0);
    idle(2);

    // R3: full-word fills, then partial lane writes
    for (int w = 0; w < 8; w++)
      rq("R3", mk(0, 0, 2'd3, 3'd0, 1, 24'(w * 8)), {8{8'(8'h10 + w)}} ^ 64'h0123_4567_89AB_CDEF);
    rq("R3", mk(0, 0, 2'd0, 3'd0, 1, 24'h03), 64'hFFFF_FFFF_FFFF_FFAA);
    rq("R3", mk(0, 0, 2'd1, 3'd0, 1, 24'h0E), 64'h0000_0000_0000_BEEF);
    rq("R3", mk(0, 0, 2'd2, 3'd0, 1, 24'h15), 64'h0000_0000_7766_5544);
    rq("R3", mk(0, 0, 2'd3, 3'd0, 1, 24'h1C), 64'h1111_2222_3333_4444);
    idle(1);

    // R4: reads of all lengths and offsets, including truncation
    for (int w = 0; w < 8; w++) rq("R4", mk(0, 0, 2'd3, 3'd0, 0, 24'(w * 8)), '0);
    rq("R4", mk(0, 0, 2'd0, 3'd0, 0, 24'h03), '0);
    rq("R4", mk(0, 0, 2'd1, 3'd0, 0, 24'h0F), '0);
    rq("R4", mk(0, 0, 2'd2, 3'd0, 0, 24'h12), '0);
    rq("R4", mk(0, 0, 2'd3, 3'd0, 0, 24'h1D), '0);
    rq("R4", mk(0, 0, 2'd1, 3'd0, 0, 24'h06), '0);

    // R5: aliasing through high address bits
    rq("R5", mk(0, 0, 2'd3, 3'd0, 1, 24'h18 + 24'(DEPTH * 8)), 64'hCAFE_F00D_D00D_BEAD);
    rq("R5", mk(0, 0, 2'd3, 3'd0, 0, 24'h18), '0);
    rq("R5", mk(0, 0, 2'd3, 3'd0, 0, 24'hF0_0018), '0);
    idle(1);

    // R6: identity register follows dev_id
    rq("R6", mk(0, 1, 2'd1, 3'd0, 0, 24'h0), '0);
    @(negedge clk); dev_id = 16'hC0DE;
    req_valid = 1'b1; req_word = mk(0, 1, 2'd1, 3'd0, 0, 24'h0); cur_tag = "R6";
    idle(1);

    // R7: pending flag set, read-clear, raise beats clear
    raise_only();
    idle(2);
    rq("R7", mk(0, 1, 2'd1, 3'd0, 0, 24'h2), '0);
    rq("R7", mk(0, 1, 2'd1, 3'd0, 0, 24'h2), '0);
    rq_raise("R7", mk(0, 1, 2'd1, 3'd0, 0, 24'h2));
    rq("R7", mk(0, 1, 2'd1, 3'd0, 0, 24'h2), '0);
    rq("R7", mk(0, 1, 2'd1, 3'd0, 0, 24'h2), '0);

    // R10: other registers read zero; writes there change nothing
    rq("R10", mk(0, 1, 2'd1, 3'd0, 0, 24'h1), '0);
    rq("R10", mk(0, 1, 2'd1, 3'd0, 0, 24'h4), '0);
    rq("R10", mk(0, 1, 2'd1, 3'd0, 0, 24'h100), '0);
    rq("R10", mk(0, 1, 2'd3, 3'd0, 1, 24'h10), 64'hDEAD_DEAD_DEAD_DEAD);
    rq("R10", mk(0, 1, 2'd0, 3'd0, 1, 24'h0), 64'h0000_0000_0000_0042);
    rq("R10", mk(0, 1, 2'd0, 3'd0, 1, 24'h6), 64'h0000_0000_0000_0043);
    rq("R10", mk(0, 0, 2'd3, 3'd0, 0, 24'h10), '0);
    rq("R10", mk(0, 1, 2'd1, 3'd0, 0, 24'h0), '0);
    idle(2);

    // R11: lock and modifier bits change nothing
    rq("R11", mk(1, 0, 2'd1, 3'd7, 1, 24'h22), 64'h0000_0000_0000_9876);
    rq("R11", mk(1, 0, 2'd3, 3'd5, 0, 24'h20), '0);
    rq("R11", mk(0, 0, 2'd3, 3'd2, 0, 24'h20), '0);
    rq("R11", mk(1, 1, 2'd1, 3'd6, 0, 24'h0), '0);
    rq("R11", mk(1, 1, 2'd0, 3'd3, 1, 24'h2), 64'h0000_0000_0000_0021);
    idle(3);

    // R8: console bytes in order, with a stall in between
    for (int i = 0; i < 5; i++) rq("R8", mk(0, 1, 2'd0, 3'd0, 1, 24'h2), 64'(8'h41 + i));
    @(negedge clk); req_valid = 1'b0; tx_ready = 1'b0;
    idle(4);
    @(negedge clk); tx_ready = 1'b1;
    idle(8);

    // R9: fill with the transmitter stalled, then overflow to saturation
    @(negedge clk); tx_ready = 1'b0;
    for (int i = 0; i < FDEPTH + 2; i++) rq("R9", mk(0, 1, 2'd0, 3'd0, 1, 24'h2), 64'(i));
    idle(2);
    for (int i = 0; i < 260; i++) rq("R9", mk(0, 1, 2'd0, 3'd0, 1, 24'h2), 64'(8'hE0));
    idle(2);
    @(negedge clk); tx_ready = 1'b1;
    idle(FDEPTH + 4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule